// File: doc/BRIEF.md
# ADC Sample-Trigger Controller

This block generates the sample window signal for a successive-approximation ADC front end. It also generates a one-cycle strobe that tells the converter to begin. A 2-bit select picks the trigger source: either a software start bit held inside the block or one of three timer outputs. The timer outputs are asynchronous and pass through a two-flop synchronizer. An optional inversion is applied to the chosen trigger, and the result is then qualified by a conversion-enable input.

The enable qualification needs a fresh trigger edge. After enable rises, the trigger must first be seen inactive and then go active again. A pulse that is already running when enable is set therefore never produces a shortened first sample. The block has two modes:

- **Timed mode:** an accepted edge loads an internal down-counter, and the sample window lasts a programmable 4 to 1024 clock cycles.
- **Gated mode:** the sample window follows the trigger's active time directly.

When the sample window ends, the strobe fires. A new trigger is then refused until the converter reports completion.

Top module: `smp_trig_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, samp_o, conv_start_o and sw_start_o are 0.
- R2: trig_sel_i selects the trigger source: 0 = software start bit, 1 = tmr_a1_i, 2 = tmr_b0_i, 3 = tmr_b1_i. An unselected source never starts a sample.
- R3: With trig_inv_i = 1, the selected source is active while it is low. With trig_inv_i = 0, it is active while it is high.
- R4: A sample starts only on an active edge seen while conv_en_i is high, and only after the trigger has been observed inactive with conv_en_i high. A trigger already active when conv_en_i rises is ignored until it has been inactive once.
- R5: With pulse_mode_i = 1, samp_o rises in the cycle after the accepted edge. It stays high for exactly 4 << min(smp_len_i, 8) cycles, so codes 8 to 15 all give 1024.
- R6: With pulse_mode_i = 0, samp_o rises one cycle after the active edge and falls one cycle after the trigger becomes inactive, so it is high for as many cycles as the trigger was active. Timer inputs add two cycles of synchronizer delay.
- R7: conv_start_o is high for exactly one cycle: the cycle right after samp_o falls.
- R8: A trigger edge is ignored while samp_o is high, and also from conv_start_o until conv_done_i is seen.
- R9: Clearing conv_en_i during a sample lets that sample run to its full width and still emit conv_start_o.
- R10: sw_start_o is set by sw_start_set_i and cleared by sw_start_clr_i. In pulse mode with select 0, it clears itself when the sample starts. In gated mode it stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Conversion enable |
| trig_sel_i | input | 2 | Trigger source select |
| trig_inv_i | input | 1 | Trigger polarity inversion |
| pulse_mode_i | input | 1 | 1 = timed sample width, 0 = trigger-gated width |
| smp_len_i | input | 4 | Sample length code for timed mode |
| sw_start_set_i | input | 1 | Sets the software start bit |
| sw_start_clr_i | input | 1 | Clears the software start bit |
| tmr_a1_i | input | 1 | Asynchronous timer output, source 1 |
| tmr_b0_i | input | 1 | Asynchronous timer output, source 2 |
| tmr_b1_i | input | 1 | Asynchronous timer output, source 3 |
| conv_done_i | input | 1 | Converter finished pulse |
| samp_o | output | 1 | Sample window |
| conv_start_o | output | 1 | One-cycle conversion start strobe |
| sw_start_o | output | 1 | Current software start bit |

## Verification
The tests cover the following trigger patterns:

- **Timed mode:** software starts at length codes 0, 2, 8 and 15, which separates the shift mapping from its clamp.
- **Gated mode:** timer pulses of 7 and 12 cycles and a software-held start, which show that the window follows the trigger's own width.
- **Source selection:** pulses on unselected timers, which separate the select decoding from a wired-OR of sources.
- **Polarity:** a low-going pulse with inversion on, which shows that polarity is applied before edge detection.
- **Enable qualification:** enable raised during a high pulse, pulses while disabled, and pulses during a sample and during conversion. These separate the fresh-edge and busy qualification from plain level gating.

// File: rtl/smp_trig_pkg.sv
package smp_trig_pkg;
  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_TA1 = 2'd1,
    SRC_TB0 = 2'd2,
    SRC_TB1 = 2'd3
  } trig_src_e;

  function automatic int unsigned smp_cycles(int unsigned code, int unsigned base_log,
                                             int unsigned max_shift);
    int unsigned sh;
    sh = (code > max_shift) ? max_shift : code;
    return 32'd1 << (base_log + sh);
  endfunction
endpackage

// File: rtl/smp_sync.sv
module smp_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/smp_arm.sv
module smp_arm
  import smp_trig_pkg::*;
#(
  parameter int unsigned NTMR = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      sel_i,
  input  logic            inv_i,
  input  logic            sw_bit_i,
  input  logic [NTMR-1:0] tmr_i,
  output logic            trig_o,
  output logic            fire_o
);
  logic raw;
  logic prev_q, armed_q;

  always_comb begin
    unique case (trig_src_e'(sel_i))
      SRC_SW:  raw = sw_bit_i;
      SRC_TA1: raw = tmr_i[0];
      SRC_TB0: raw = tmr_i[1];
      default: raw = tmr_i[2];
    endcase
  end

  assign trig_o = raw ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= trig_o;
      if (!en_i)        armed_q <= 1'b0;
      else if (!trig_o) armed_q <= 1'b1;
    end
  end

  // fresh edge only after an inactive observation under enable
  assign fire_o = en_i && armed_q && trig_o && !prev_q;

  a_r4_no_fire_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !fire_o);
endmodule

// File: rtl/smp_timer.sv
module smp_timer
  import smp_trig_pkg::*;
#(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BASE_LOG  = 2,
  parameter int unsigned MAX_SHIFT = 8,
  parameter int unsigned CNT_W     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;

  assign len = CNT_W'(smp_cycles(int'(code_i), BASE_LOG, MAX_SHIFT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = cnt_q != '0;

  a_r5_steady_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/smp_trig_ctrl.sv
module smp_trig_ctrl
  import smp_trig_pkg::*;
#(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BASE_LOG  = 2,
  parameter int unsigned MAX_SHIFT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_en_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              trig_inv_i,
  input  logic              pulse_mode_i,
  input  logic [CODE_W-1:0] smp_len_i,
  input  logic              sw_start_set_i,
  input  logic              sw_start_clr_i,
  input  logic              tmr_a1_i,
  input  logic              tmr_b0_i,
  input  logic              tmr_b1_i,
  input  logic              conv_done_i,
  output logic              samp_o,
  output logic              conv_start_o,
  output logic              sw_start_o
);
  localparam int unsigned NTMR    = 3;
  localparam int unsigned MAX_LEN = 1 << (BASE_LOG + MAX_SHIFT);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [NTMR-1:0] tmr_sync;
  logic trig_lvl, fire, accept, idle, tmr_active;
  logic ext_q, samp_prev_q, conv_busy_q, sw_bit_q;

  smp_sync #(.W(NTMR)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tmr_b1_i, tmr_b0_i, tmr_a1_i}),
    .q_o   (tmr_sync)
  );

  smp_arm #(.NTMR(NTMR)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (conv_en_i),
    .sel_i   (trig_sel_i),
    .inv_i   (trig_inv_i),
    .sw_bit_i(sw_bit_q),
    .tmr_i   (tmr_sync),
    .trig_o  (trig_lvl),
    .fire_o  (fire)
  );

  smp_timer #(
    .CODE_W(CODE_W), .BASE_LOG(BASE_LOG), .MAX_SHIFT(MAX_SHIFT), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && pulse_mode_i),
    .code_i  (smp_len_i),
    .active_o(tmr_active)
  );

  assign samp_o       = ext_q | tmr_active;
  assign conv_start_o = samp_prev_q & ~samp_o;
  assign idle         = !samp_o && !conv_busy_q && !conv_start_o;
  assign accept       = fire && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q       <= 1'b0;
      samp_prev_q <= 1'b0;
      conv_busy_q <= 1'b0;
      sw_bit_q    <= 1'b0;
    end else begin
      samp_prev_q <= samp_o;
      if (accept && !pulse_mode_i) ext_q <= 1'b1;
      else if (!trig_lvl)          ext_q <= 1'b0;
      if (conv_start_o)            conv_busy_q <= 1'b1;
      else if (conv_done_i)        conv_busy_q <= 1'b0;
      // self-clear wins over a concurrent set
      if (accept && pulse_mode_i && trig_src_e'(trig_sel_i) == SRC_SW) sw_bit_q <= 1'b0;
      else if (sw_start_set_i) sw_bit_q <= 1'b1;
      else if (sw_start_clr_i) sw_bit_q <= 1'b0;
    end
  end

  assign sw_start_o = sw_bit_q;

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  a_r7_strobe_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(samp_o) |-> conv_start_o);
  a_r8_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(samp_o) |-> (!$past(conv_busy_q) && $past(conv_en_i)));
  a_r10_sw_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(samp_o) && $past(pulse_mode_i) && $past(trig_sel_i) == 2'd0) |-> !sw_start_o);
  a_r6_gated_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_q && !trig_lvl) |=> !ext_q);
endmodule

// File: tb/smp_trig_ctrl_tb_top.sv
module smp_trig_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, inv = 1'b0, pmode = 1'b1, sw_set = 1'b0, sw_clr = 1'b0;
  logic ta1 = 1'b0, tb0 = 1'b0, tb1 = 1'b0, conv_done = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [3:0] code = 4'd0;
  logic samp, conv_start, sw_bit;

  int checks = 0;
  int fails = 0;
  int rise_cnt = 0;
  int exp_w_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  smp_trig_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_en_i(en), .trig_sel_i(sel), .trig_inv_i(inv),
    .pulse_mode_i(pmode), .smp_len_i(code), .sw_start_set_i(sw_set),
    .sw_start_clr_i(sw_clr), .tmr_a1_i(ta1), .tmr_b0_i(tb0), .tmr_b1_i(tb1),
    .conv_done_i(conv_done), .samp_o(samp), .conv_start_o(conv_start), .sw_start_o(sw_bit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int w, input string tag);
    exp_w_q.push_back(w);
    exp_tag_q.push_back(tag);
  endtask

  task automatic sw_start();
    @(posedge clk); #1 sw_set = 1'b1;
    @(posedge clk); #1 sw_set = 1'b0;
  endtask

  task automatic sw_hold(input int n);
    @(posedge clk); #1 sw_set = 1'b1;
    @(posedge clk); #1 sw_set = 1'b0;
    repeat (n - 2) @(posedge clk);
    @(negedge clk);
    check(sw_bit == 1'b1, "R10 held in gated mode", int'(sw_bit), 1);
    @(posedge clk); #1 sw_clr = 1'b1;
    @(posedge clk); #1 sw_clr = 1'b0;
  endtask

  task automatic tmr_drive(input int idx, input logic v);
    case (idx)
      1: ta1 = v;
      2: tb0 = v;
      default: tb1 = v;
    endcase
  endtask

  task automatic tmr_pulse(input int idx, input int hi, input logic act);
    @(posedge clk); #1 tmr_drive(idx, act);
    repeat (hi) @(posedge clk);
    #1 tmr_drive(idx, ~act);
  endtask

  task automatic settle();
    while (exp_w_q.size() != 0) @(posedge clk);
    repeat (30) @(posedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int run;
    logic prev;
    int w;
    string tag;
    run = 0;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (samp) begin
        if (!prev) rise_cnt++;
        run++;
      end else if (prev) begin
        if (exp_w_q.size() == 0) begin
          check(1'b0, "R8 unexpected sample", run, 0);
        end else begin
          w = exp_w_q.pop_front();
          tag = exp_tag_q.pop_front();
          check(run == w, tag, run, w);
        end
        check(conv_start == 1'b1, "R7 strobe after fall", int'(conv_start), 1);
        run = 0;
      end
      if (conv_start && !(prev && !samp))
        check(1'b0, "R7 stray strobe", int'(conv_start), 0);
      prev = samp;
    end
  end

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (20) @(posedge clk);
        #1 conv_done = 1'b1;
        @(posedge clk); #1 conv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(samp == 1'b0, "R1 samp in reset", int'(samp), 0);
    check(conv_start == 1'b0, "R1 strobe in reset", int'(conv_start), 0);
    check(sw_bit == 1'b0, "R1 sw bit in reset", int'(sw_bit), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(samp == 1'b0 && sw_bit == 1'b0, "R1 after release", int'(samp), 0);

    en = 1'b1; pmode = 1'b1; sel = 2'd0; code = 4'd0;
    repeat (3) @(posedge clk);

    // R5 timed widths
    expect_pulse(4, "R5 code0");
    sw_start();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sw_bit == 1'b0, "R10 self clear", int'(sw_bit), 0);
    settle();
    code = 4'd2; expect_pulse(16, "R5 code2"); sw_start(); settle();
    code = 4'd8; expect_pulse(1024, "R5 code8"); sw_start(); settle();
    code = 4'd15; expect_pulse(1024, "R5 code15 clamp"); sw_start(); settle();

    // R2 select
    code = 4'd0; sel = 2'd1;
    repeat (3) @(posedge clk);
    base = rise_cnt;
    tmr_pulse(2, 3, 1'b1);
    tmr_pulse(3, 3, 1'b1);
    repeat (10) @(posedge clk);
    check(rise_cnt == base, "R2 unselected ignored", rise_cnt - base, 0);
    expect_pulse(4, "R2 sel1 timer");
    tmr_pulse(1, 3, 1'b1);
    settle();

    // R6 gated widths
    pmode = 1'b0; sel = 2'd2;
    repeat (3) @(posedge clk);
    expect_pulse(7, "R6 sel2 width7"); tmr_pulse(2, 7, 1'b1); settle();
    sel = 2'd3;
    repeat (3) @(posedge clk);
    expect_pulse(12, "R6 sel3 width12"); tmr_pulse(3, 12, 1'b1); settle();
    sel = 2'd0;
    repeat (3) @(posedge clk);
    expect_pulse(9, "R10 gated sw width"); sw_hold(9); settle();

    // R3 polarity
    en = 1'b0; sel = 2'd2; inv = 1'b1; tb0 = 1'b1;
    repeat (4) @(posedge clk);
    en = 1'b1;
    repeat (3) @(posedge clk);
    expect_pulse(5, "R3 inverted low pulse");
    tmr_pulse(2, 5, 1'b0);
    settle();
    en = 1'b0; inv = 1'b0; tb0 = 1'b0;
    repeat (4) @(posedge clk);

    // R4 enable in the middle of a pulse
    sel = 2'd3; tb1 = 1'b1;
    repeat (4) @(posedge clk);
    #1 en = 1'b1;
    base = rise_cnt;
    repeat (6) @(posedge clk);
    #1 tb1 = 1'b0;
    repeat (10) @(posedge clk);
    check(rise_cnt == base, "R4 pulse in progress ignored", rise_cnt - base, 0);
    expect_pulse(4, "R4 fresh pulse accepted");
    tmr_pulse(3, 4, 1'b1);
    settle();
    #1 en = 1'b0;
    base = rise_cnt;
    tmr_pulse(3, 4, 1'b1);
    repeat (10) @(posedge clk);
    check(rise_cnt == base, "R4 disabled ignored", rise_cnt - base, 0);
    #1 en = 1'b1;
    repeat (5) @(posedge clk);

    // R8 busy
    pmode = 1'b1; sel = 2'd1; code = 4'd2;
    repeat (3) @(posedge clk);
    base = rise_cnt;
    expect_pulse(16, "R8 first sample");
    tmr_pulse(1, 2, 1'b1);
    repeat (6) @(posedge clk);
    tmr_pulse(1, 2, 1'b1);
    do @(negedge clk); while (!conv_start);
    repeat (3) @(posedge clk);
    tmr_pulse(1, 2, 1'b1);
    settle();
    check(rise_cnt == base + 1, "R8 busy triggers ignored", rise_cnt - base, 1);
    expect_pulse(16, "R8 accepted after done");
    tmr_pulse(1, 2, 1'b1);
    settle();

    // R9 enable cleared during sample
    sel = 2'd0; code = 4'd3;
    repeat (3) @(posedge clk);
    expect_pulse(32, "R9 sample completes");
    sw_start();
    repeat (5) @(posedge clk);
    #1 en = 1'b0;
    settle();
    #1 en = 1'b1;
    repeat (3) @(posedge clk);

    check(exp_w_q.size() == 0, "R5 all samples seen", exp_w_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule